// File: doc/BRIEF.md
# Relocatable Memory Window Peripheral Decoder

This block is the address glue for an 8-bit expansion card on a 20-bit bus. It maps three devices into one 16 KB window of upper memory: a flash ROM, a bank of eight disk task-file registers and a real-time clock with a 4-bit data path. A 3-bit switch value places the window at one of eight positions from C0000h to DFFFFh. The window base is C0000h plus the switch value times 4000h.

Inside the window, the lower 8 KB selects the flash. The disk registers start at the first byte of the upper half. They are spread 8 bytes apart, so their index comes from address bits 5:3. The sixteen clock registers follow directly above them, and their index comes from address bits 3:0.

Every chip select is blanked while the address latch enable is high. Two back-to-back cycles to the same device therefore produce two separate strobes. A data buffer between the card and the bus is enabled only for a decoded device during a memory strobe, and it is turned toward the bus on reads. On a clock read, the byte handed to the bus carries the clock's nibble with the upper four bits held at zero. The decode is purely combinational.

Top module: `pw_decode`

## Requirements
- R1: A memory cycle is claimed only when `addr` lies in [C0000h + `win_sel`×4000h, C0000h + `win_sel`×4000h + 3FFFh]. Any address outside that range leaves all three chip selects (active low) at 1.
- R2: Window offsets 0000h–1FFFh drive `flash_cs_n` to 0.
- R3: Window offsets 2000h–203Fh drive `ide_cs_n` to 0, with `ide_a` = `addr`[5:3].
- R4: Window offsets 2040h–204Fh drive `rtc_cs_n` to 0, with `rtc_a` = `addr`[3:0].
- R5: Window offsets 2050h–3FFFh assert no chip select and leave `buf_en_n` at 1.
- R6: While `ale` is 1, all three chip selects and `buf_en_n` are 1, whatever the address.
- R7: When `io_sel` is 1 (an I/O-space cycle), no chip select is asserted and `buf_en_n` is 1.
- R8: `buf_en_n` is 0 exactly when one chip select is 0 and at least one of `memr_n` and `memw_n` is 0.
- R9: `buf_dir` is 1 (toward the bus) when `memr_n` is 0, and 0 (toward the card) otherwise.
- R10: When `rtc_cs_n` is 0 and `memr_n` is 0, `rtc_rd_byte` = {4'h0, `rtc_nib`}. At all other times it is 8'h00.
- R11: At most one of the three chip selects is 0 at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | 20 | Bus address |
| memr_n | input | 1 | Memory read strobe, active low |
| memw_n | input | 1 | Memory write strobe, active low |
| io_sel | input | 1 | 1 = I/O-space cycle, 0 = memory-space cycle |
| ale | input | 1 | Address latch enable, high between cycles |
| win_sel | input | 3 | Window position switches |
| rtc_nib | input | 4 | Data nibble from the clock chip |
| flash_cs_n | output | 1 | Flash chip select, active low |
| ide_cs_n | output | 1 | Disk register bank select, active low |
| rtc_cs_n | output | 1 | Clock chip select, active low |
| ide_a | output | 3 | Disk register index |
| rtc_a | output | 4 | Clock register index |
| buf_en_n | output | 1 | Data buffer enable, active low |
| buf_dir | output | 1 | Data buffer direction, 1 = toward bus |
| rtc_rd_byte | output | 8 | Clock read byte with the upper nibble zeroed |

## Verification
Two conditions can be present in the same cycle. An address decode can be valid for a device while the latch enable is still high, and in that case the blanking must win. A clock read can also coincide with the buffer turning toward the bus, and the zeroed upper nibble must appear in that same cycle. The bench provokes the first by raising `ale` on addresses that decode to each of the three devices. It provokes the second by holding a clock address with `memr_n` low and `ale` low. In both cases every output is compared with values derived from the window arithmetic.

// File: rtl/pw_decode_pkg.sv
// Shared constants and types for the memory window decoder.
// Assumes a 20-bit bus and a window size that is a power of two.
package pw_decode_pkg;
    localparam int unsigned ADDR_W   = 20;
    localparam int unsigned SEL_W    = 3;
    localparam int unsigned WIN_LOG2 = 14;
    localparam logic [19:0] WIN_BASE = 20'hC0000;

    // Which device, if any, the current address falls on.
    typedef enum logic [1:0] {
        RGN_NONE  = 2'd0,
        RGN_FLASH = 2'd1,
        RGN_IDE   = 2'd2,
        RGN_RTC   = 2'd3
    } region_e;
endpackage

// File: rtl/pw_window_match.sv
// Compares the upper address bits with the switch-selected window tag.
// Assumes BASE is aligned to 2**WIN_LOG2 and the window never wraps.
module pw_window_match #(
    parameter int unsigned ADDR_W   = 20,
    parameter int unsigned SEL_W    = 3,
    parameter int unsigned WIN_LOG2 = 14,
    parameter logic [ADDR_W-1:0] BASE = 20'hC0000
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [SEL_W-1:0]    sel,
    input  logic                mem_cycle,
    output logic                hit,
    output logic [WIN_LOG2-1:0] offset
);
    localparam int unsigned TAG_W = ADDR_W - WIN_LOG2;
    localparam logic [TAG_W-1:0] BASE_TAG = BASE[ADDR_W-1:WIN_LOG2];

    logic [TAG_W-1:0] want_tag;

    // Window tag = base tag plus switch value; claim on a tag match.
    always_comb begin
        want_tag = BASE_TAG + TAG_W'(sel);
        hit      = mem_cycle && (addr[ADDR_W-1:WIN_LOG2] == want_tag);
        offset   = addr[WIN_LOG2-1:0];
    end
endmodule

// File: rtl/pw_region_decode.sv
// Splits a window offset into flash, disk register and clock ranges.
// Assumes the register span 2**(IDE_SHIFT+IDE_IDX_W) is a multiple of
// the clock span 2**RTC_IDX_W, and both fit within the upper half.
module pw_region_decode
    import pw_decode_pkg::*;
#(
    parameter int unsigned WIN_LOG2  = 14,
    parameter int unsigned IDE_SHIFT = 3,
    parameter int unsigned IDE_IDX_W = 3,
    parameter int unsigned RTC_IDX_W = 4
) (
    input  logic                 hit,
    input  logic [WIN_LOG2-1:0]  offset,
    output region_e              region,
    output logic [IDE_IDX_W-1:0] ide_idx,
    output logic [RTC_IDX_W-1:0] rtc_idx
);
    localparam int unsigned HALF     = WIN_LOG2 - 1;
    localparam int unsigned IDE_SPAN = IDE_SHIFT + IDE_IDX_W;
    localparam int unsigned IDE_TW   = HALF - IDE_SPAN;
    localparam int unsigned RTC_TW   = HALF - RTC_IDX_W;
    localparam int unsigned RTC_TAG  = (1 << IDE_SPAN) >> RTC_IDX_W;

    logic in_ide;
    logic in_rtc;

    // Range tests within the upper half of the window.
    always_comb begin
        in_ide = offset[HALF] && (offset[HALF-1:IDE_SPAN] == IDE_TW'(0));
        in_rtc = offset[HALF] &&
                 (offset[HALF-1:RTC_IDX_W] == RTC_TW'(RTC_TAG));
    end

    // Region priority: lower half is flash, then registers, then clock.
    always_comb begin
        if (!hit)                region = RGN_NONE;
        else if (!offset[HALF])  region = RGN_FLASH;
        else if (in_ide)         region = RGN_IDE;
        else if (in_rtc)         region = RGN_RTC;
        else                     region = RGN_NONE;
    end

    // Register indices come straight from the address bits.
    always_comb begin
        ide_idx = offset[IDE_SPAN-1:IDE_SHIFT];
        rtc_idx = offset[RTC_IDX_W-1:0];
    end
endmodule

// File: rtl/pw_bus_steer.sv
// Turns a decoded region into blanked chip selects, buffer control and
// the zero-padded clock read byte.
// Assumes the strobes and ale are already synchronous to the bus cycle.
module pw_bus_steer
    import pw_decode_pkg::*;
#(
    parameter int unsigned NIB_W  = 4,
    parameter int unsigned BYTE_W = 8
) (
    input  region_e           region,
    input  logic              ale,
    input  logic              memr_n,
    input  logic              memw_n,
    input  logic [NIB_W-1:0]  rtc_nib,
    output logic              flash_cs_n,
    output logic              ide_cs_n,
    output logic              rtc_cs_n,
    output logic              buf_en_n,
    output logic              buf_dir,
    output logic [BYTE_W-1:0] rtc_rd_byte
);
    localparam int unsigned N_DEV = 3;

    logic [N_DEV-1:0] sel_act;

    // One active-high select per device, blanked while ale is high.
    for (genvar g = 0; g < N_DEV; g++) begin : g_cs
        always_comb sel_act[g] = !ale && (region == region_e'(g + 1));
    end

    // Active-low chip selects.
    always_comb begin
        flash_cs_n = !sel_act[0];
        ide_cs_n   = !sel_act[1];
        rtc_cs_n   = !sel_act[2];
    end

    // Buffer opens for a decoded device during a memory strobe.
    always_comb begin
        buf_en_n = !((|sel_act) && (!memr_n || !memw_n));
        buf_dir  = !memr_n;
    end

    // Clock reads return the nibble with the upper bits held at zero.
    always_comb begin
        if (sel_act[2] && !memr_n)
            rtc_rd_byte = {{(BYTE_W-NIB_W){1'b0}}, rtc_nib};
        else
            rtc_rd_byte = '0;
    end
endmodule

// File: rtl/pw_decode.sv
// Top of the memory window decoder: window match, region split and bus
// steering. Purely combinational; no clock or reset is needed.
module pw_decode
    import pw_decode_pkg::*;
(
    input  logic [19:0] addr,
    input  logic        memr_n,
    input  logic        memw_n,
    input  logic        io_sel,
    input  logic        ale,
    input  logic [2:0]  win_sel,
    input  logic [3:0]  rtc_nib,
    output logic        flash_cs_n,
    output logic        ide_cs_n,
    output logic        rtc_cs_n,
    output logic [2:0]  ide_a,
    output logic [3:0]  rtc_a,
    output logic        buf_en_n,
    output logic        buf_dir,
    output logic [7:0]  rtc_rd_byte
);
    logic                hit;
    logic [WIN_LOG2-1:0] offset;
    region_e             region;
    logic                mem_cycle;

    // Only memory-space cycles take part in the decode.
    always_comb mem_cycle = !io_sel;

    pw_window_match #(
        .ADDR_W  (ADDR_W),
        .SEL_W   (SEL_W),
        .WIN_LOG2(WIN_LOG2),
        .BASE    (WIN_BASE)
    ) u_match (
        .addr     (addr),
        .sel      (win_sel),
        .mem_cycle(mem_cycle),
        .hit      (hit),
        .offset   (offset)
    );

    pw_region_decode #(
        .WIN_LOG2 (WIN_LOG2),
        .IDE_SHIFT(3),
        .IDE_IDX_W(3),
        .RTC_IDX_W(4)
    ) u_region (
        .hit    (hit),
        .offset (offset),
        .region (region),
        .ide_idx(ide_a),
        .rtc_idx(rtc_a)
    );

    pw_bus_steer #(
        .NIB_W (4),
        .BYTE_W(8)
    ) u_steer (
        .region     (region),
        .ale        (ale),
        .memr_n     (memr_n),
        .memw_n     (memw_n),
        .rtc_nib    (rtc_nib),
        .flash_cs_n (flash_cs_n),
        .ide_cs_n   (ide_cs_n),
        .rtc_cs_n   (rtc_cs_n),
        .buf_en_n   (buf_en_n),
        .buf_dir    (buf_dir),
        .rtc_rd_byte(rtc_rd_byte)
    );
endmodule

// File: rtl/pw_decode_chk.sv
// Port-level checker for the window decoder, bound to every instance.
// Assumes settled combinational values; uses immediate assertions only.
module pw_decode_chk (
    input logic [19:0] addr,
    input logic        memr_n,
    input logic        memw_n,
    input logic        io_sel,
    input logic        ale,
    input logic [2:0]  win_sel,
    input logic [3:0]  rtc_nib,
    input logic        flash_cs_n,
    input logic        ide_cs_n,
    input logic        rtc_cs_n,
    input logic [2:0]  ide_a,
    input logic [3:0]  rtc_a,
    input logic        buf_en_n,
    input logic        buf_dir,
    input logic [7:0]  rtc_rd_byte
);
    logic [2:0] cs_low;
    logic       unused_ok;

    // Collect active selects and mark the ports this checker ignores.
    always_comb begin
        cs_low    = {!rtc_cs_n, !ide_cs_n, !flash_cs_n};
        unused_ok = ^{addr[19:6], win_sel, ide_a, rtc_a, buf_dir};
    end

    // Port relations that must hold whenever the inputs are settled.
    always_comb begin
        AST_ONE_SELECT: assert ($countones(cs_low) <= 1)
            else $error("more than one select active"); // R11
        AST_ALE_BLANK: assert (!ale || cs_low == 3'b000)
            else $error("select active while ale high"); // R6
        AST_IO_IGNORED: assert (!io_sel || (cs_low == 3'b000 && buf_en_n))
            else $error("select active in I/O cycle"); // R7
        AST_BUF_NEEDS_CS: assert (buf_en_n || cs_low != 3'b000)
            else $error("buffer open without a select"); // R8
        AST_BUF_NEEDS_STROBE: assert (buf_en_n || !memr_n || !memw_n)
            else $error("buffer open without a strobe"); // R8
        AST_RTC_HI_ZERO: assert (rtc_rd_byte[7:4] == 4'h0)
            else $error("clock byte upper nibble not zero"); // R10
        AST_RTC_BYTE_QUIET: assert (!(rtc_cs_n || memr_n) ||
                                    rtc_rd_byte == 8'h00)
            else $error("clock byte driven outside a clock read"); // R10
        AST_RTC_BYTE_NIB: assert (rtc_cs_n || memr_n ||
                                  rtc_rd_byte[3:0] == rtc_nib)
            else $error("clock byte does not carry nibble"); // R10
    end
endmodule

bind pw_decode pw_decode_chk chk_i (.*);

// File: tb/pw_decode_tb_top.sv
// Directed bench for the memory window decoder.
module pw_decode_tb_top;
    logic        clk;
    logic        rst_n;
    logic [19:0] addr;
    logic        memr_n, memw_n, io_sel, ale;
    logic [2:0]  win_sel;
    logic [3:0]  rtc_nib;
    logic        flash_cs_n, ide_cs_n, rtc_cs_n;
    logic [2:0]  ide_a;
    logic [3:0]  rtc_a;
    logic        buf_en_n, buf_dir;
    logic [7:0]  rtc_rd_byte;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    pw_decode dut_i (.*);

    // 100 MHz clock.
    initial clk = 0;
    always #5 clk = ~clk;

    // Compare one value and log a failure with the requirement tag.
    task automatic chk(input string tag, input string what,
                       input logic [19:0] act, input logic [19:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s addr=%h sel=%0d actual=%h expected=%h",
                     tag, what, addr, win_sel, act, exp);
        end
    endtask

    // Drive a cycle at the falling edge, then check settled outputs.
    task automatic apply(input logic [19:0] a, input logic [2:0] s,
                         input logic rd_n, input logic wr_n,
                         input logic io, input logic le,
                         input logic [3:0] nib, input string tag);
        logic [19:0] base;
        logic [19:0] off;
        logic        inwin;
        logic        f, i, r, en, dir;
        logic [7:0]  byte_e;
        @(negedge clk);
        addr = a; win_sel = s; memr_n = rd_n; memw_n = wr_n;
        io_sel = io; ale = le; rtc_nib = nib;
        #2;
        base  = 20'hC0000 + 20'(s) * 20'h4000;
        inwin = (a >= base) && (a <= base + 20'h3FFF) && !io && !le;
        off   = a - base;
        f     = inwin && off <  20'h2000;
        i     = inwin && off >= 20'h2000 && off <= 20'h203F;
        r     = inwin && off >= 20'h2040 && off <= 20'h204F;
        en    = (f || i || r) && (!rd_n || !wr_n);
        dir   = !rd_n;
        byte_e = (r && !rd_n) ? {4'h0, nib} : 8'h00;
        chk(tag, "flash_cs_n", 20'(flash_cs_n), 20'(!f));
        chk(tag, "ide_cs_n",   20'(ide_cs_n),   20'(!i));
        chk(tag, "rtc_cs_n",   20'(rtc_cs_n),   20'(!r));
        chk(tag, "buf_en_n",   20'(buf_en_n),   20'(!en));
        chk(tag, "buf_dir",    20'(buf_dir),    20'(dir));
        chk(tag, "rtc_rd_byte", 20'(rtc_rd_byte), 20'(byte_e));
        if (i) chk(tag, "ide_a", 20'(ide_a), 20'(a[5:3]));
        if (r) chk(tag, "rtc_a", 20'(rtc_a), 20'(a[3:0]));
    endtask

    // Idle bus: latch enable high, strobes off, nothing selected.
    task automatic t_reset_state();
        apply(20'hC0000, 3'd0, 1'b1, 1'b1, 1'b0, 1'b1, 4'h0, "R6");
    endtask

    // Every switch value with the window edges and region edges (R1..R5).
    task automatic t_sweep();
        logic [19:0] offs [10];
        string       tags [10];
        offs = '{20'h0000, 20'h1FFF, 20'h2000, 20'h203F, 20'h2040,
                 20'h204F, 20'h2050, 20'h3FFF, 20'h4000, 20'hFFFFF};
        tags = '{"R2", "R2", "R3", "R3", "R4",
                 "R4", "R5", "R5", "R1", "R1"};
        for (int s = 0; s < 8; s++) begin
            logic [19:0] b;
            b = 20'hC0000 + 20'(s) * 20'h4000;
            apply(b - 20'h1, 3'(s), 1'b0, 1'b1, 1'b0, 1'b0, 4'h5, "R1");
            for (int k = 0; k < 10; k++) begin
                logic [19:0] a;
                a = (k == 9) ? 20'h00400 : b + offs[k];
                apply(a, 3'(s), 1'b0, 1'b1, 1'b0, 1'b0, 4'h5, tags[k]);
            end
        end
    endtask

    // Register indices: each disk register and each clock register.
    task automatic t_indices();
        for (int n = 0; n < 8; n++)
            apply(20'hC6000 + 20'(n * 8) + 20'(n & 7), 3'd1,
                  1'b1, 1'b0, 1'b0, 1'b0, 4'h0, "R3");
        for (int n = 0; n < 16; n++)
            apply(20'hDE040 + 20'(n), 3'd7,
                  1'b0, 1'b1, 1'b0, 1'b0, 4'(15 - n), "R4");
    endtask

    // Latch enable high on addresses that decode to each device.
    task automatic t_ale_blank();
        apply(20'hD0010, 3'd4, 1'b0, 1'b1, 1'b0, 1'b1, 4'h3, "R6");
        apply(20'hD2008, 3'd4, 1'b1, 1'b0, 1'b0, 1'b1, 4'h3, "R6");
        apply(20'hD2041, 3'd4, 1'b0, 1'b1, 1'b0, 1'b1, 4'hA, "R6");
        apply(20'hD2041, 3'd4, 1'b0, 1'b1, 1'b0, 1'b0, 4'hA, "R6");
        apply(20'hD2041, 3'd4, 1'b0, 1'b1, 1'b0, 1'b1, 4'hA, "R6");
    endtask

    // I/O-space cycles on decodable addresses.
    task automatic t_io_ignored();
        apply(20'hC8000, 3'd2, 1'b0, 1'b1, 1'b1, 1'b0, 4'h1, "R7");
        apply(20'hCA010, 3'd2, 1'b1, 1'b0, 1'b1, 1'b0, 4'h1, "R7");
        apply(20'hCA04F, 3'd2, 1'b0, 1'b1, 1'b1, 1'b0, 4'h1, "R7");
    endtask

    // Strobe combinations for buffer enable and direction.
    task automatic t_buffer();
        apply(20'hCC100, 3'd3, 1'b1, 1'b1, 1'b0, 1'b0, 4'h0, "R8");
        apply(20'hCC100, 3'd3, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, "R9");
        apply(20'hCE000, 3'd3, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0, "R9");
        apply(20'hCE3F0, 3'd3, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, "R8");
    endtask

    // Clock reads and writes: zeroed upper nibble only on reads.
    task automatic t_rtc_byte();
        apply(20'hC4047, 3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 4'hF, "R10");
        apply(20'hC4047, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 4'hF, "R10");
        apply(20'hC0047, 3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 4'hF, "R10");
        apply(20'hC404C, 3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 4'h9, "R11");
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_chk, n_fail);
            $finish;
        end
    end

    // Main sequence.
    initial begin
        rst_n = 0; addr = '0; memr_n = 1; memw_n = 1; io_sel = 0;
        ale = 1; win_sel = '0; rtc_nib = '0;
        repeat (3) @(posedge clk);
        rst_n = 1;
        t_reset_state();
        t_sweep();
        t_indices();
        t_ale_blank();
        t_io_ignored();
        t_buffer();
        t_rtc_byte();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_chk, n_fail);
        $finish;
    end
endmodule